// File: doc/BRIEF.md
# Drive Port Enable and Ready Controller

This block decides, every clock cycle, how the parallel drive interface of a storage bridge is presented to the outside world. It watches four asynchronous inputs: a drive-ready line, a media-present line, a bus-share enable and an active-low eject button. From them it selects one of three port modes: released (all drive pins high-Z, so another host can own the bus), forced-zero (pins driven low, drive logic idle), or active (pins driven by the drive protocol engine). It also sequences a timed drive reset pulse whenever the drive becomes usable.

The ready line passes through an asymmetric filter. It must stay asserted for a long qualification interval before it counts, and it drops out as soon as it deasserts. Once ready is qualified, a settle interval runs before the reset pulse. Re-enabling bus sharing while ready is already qualified gives a reset pulse at once, with no settle interval. When the media-present function is enabled and media is absent, the block removes the USB D+ pull-up, raises a low-power indicator and forces the port to zero. A held eject button raises a one-cycle eject event. While the USB side is suspended with remote wakeup allowed, any edge on the eject button raises a one-cycle wakeup request.

Configuration inputs select the polarity of the ready and media inputs and whether the media input is used at all. All intervals are parameters. Their defaults assume a 30 MHz clock: 25 ms for qualification and settle, 10 ms for eject, and 25 us for the reset pulse.

Top module: `drive_port_ctrl`

## Requirements
- R1: The ready input counts as asserted when it equals `cfg_rdy_pol` (1 = active high, 0 = active low). Changing the polarity setting takes effect without new synchronizer delay.
- R2: Ready is qualified only after QUAL_CYC consecutive asserted cycles at the filter, so a shorter pulse produces no drive reset. When ready deasserts, the qualification clears and the port leaves active mode by the fourth rising edge.
- R3: After ready becomes qualified (with share enabled and media present), the controller waits SETTLE_CYC cycles and then asserts `drv_rst` for exactly RST_CYC cycles. Counting the first rising edge after the ready input changes as edge 1, `drv_rst` is first high after edge QUAL_CYC+SETTLE_CYC+3. No drive reset occurs in any other case than R3, R7 and R8.
- R4: Forced-zero mode (share enabled, port not running) shows `drv_oe`=1, `drv_active`=0, `bus_pu_oe`=1 and `bus_pu_val`=0.
- R5: After the reset pulse ends, the port is in active mode: `drv_oe`=1, `drv_active`=1 and `bus_pu_val`=1.
- R6: With `share_en` low, the port is released by the fourth rising edge: `drv_oe`=0, `bus_pu_oe`=0, `drv_rst`=0. `dplus_pu` does not change.
- R7: When `share_en` returns high while ready is still qualified, `drv_rst` is first high after rising edge 3. It lasts RST_CYC cycles and is followed by active mode.
- R8: With `cfg_media_en`=1, media counts as present when `media_in` equals `cfg_media_pol`. While it is absent, `dplus_pu`=0, `low_pwr`=1 and the port is in forced-zero mode. When media returns, the settle interval and reset pulse run again, with `drv_rst` first high after edge SETTLE_CYC+4. With `cfg_media_en`=0, the media input has no effect.
- R9: Holding `eject_n` low for EJECT_CYC synchronized cycles gives exactly one single-cycle `eject_evt` pulse. A shorter press gives none.
- R10: While `usb_suspend`=1 and `wake_en`=1, each edge of `eject_n` gives a single-cycle `wake_req` pulse. With `wake_en`=0, no pulse appears.
- R11: During reset, `drv_oe`=0, `drv_active`=0, `drv_rst`=0, `bus_pu_oe`=0, `dplus_pu`=0 and `low_pwr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rdy_pol | input | 1 | Ready polarity: 1 active high |
| cfg_media_en | input | 1 | Enable the media-present function |
| cfg_media_pol | input | 1 | Media polarity: 1 active high |
| rdy_in | input | 1 | Asynchronous drive-ready input |
| media_in | input | 1 | Asynchronous media-present input |
| share_en | input | 1 | Bus-share enable, 0 releases the drive bus |
| eject_n | input | 1 | Asynchronous eject button, active low |
| usb_suspend | input | 1 | USB side is suspended |
| wake_en | input | 1 | Host allows remote wakeup |
| drv_oe | output | 1 | Drive pin output enable (0 = high-Z) |
| drv_active | output | 1 | 1 = pins follow protocol engine, 0 = forced zero |
| drv_rst | output | 1 | Drive reset strobe, active high |
| bus_pu_oe | output | 1 | Output enable of the drive-bus pull-up control |
| bus_pu_val | output | 1 | Drive-bus pull-up control value (1 = bus active) |
| dplus_pu | output | 1 | USB D+ pull-up enable |
| low_pwr | output | 1 | Low-power indicator |
| eject_evt | output | 1 | Single-cycle eject request event |
| wake_req | output | 1 | Single-cycle remote wakeup request |

## Verification
The bench targets several ways the design could go wrong. A ready pulse a few cycles short of qualification must give no reset; a filter that counted non-consecutive cycles, or started its count one cycle early, would fire an unexpected reset. The exact cycle on which the reset pulse rises is checked for three entry paths: a fresh ready qualification, a share re-enable and a media return. A missing settle interval, a skipped reshare reset or an off-by-one counter would each move that edge or the pulse width. The bench also checks that a polarity flip or a disabled media function changes nothing except what it should. A short eject press must not produce an eject event, yet in suspend each edge of the same press must give one wakeup pulse.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    ST_HIZ,
    ST_IDLE,
    ST_WAIT,
    ST_RST,
    ST_RUN
  } port_st_e;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/dpc_qual_filter.sv
module dpc_qual_filter #(
  parameter int CYC = 750000
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic q
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!a) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!q) begin
      if (cnt == LAST) q <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R2: deassertion clears the qualified flag on the next edge
  a_r2_clear_at_once: assert property (@(posedge clk) disable iff (rst)
    !a |=> !q);
  // R2: the flag never rises without the input having been asserted
  a_r2_rise_needs_input: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(a));
endmodule

// File: rtl/dpc_port_seq.sv
module dpc_port_seq
  import dpc_pkg::*;
#(
  parameter int SETTLE_CYC = 750000,
  parameter int RST_CYC    = 750
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     share,
  input  logic     media_ok,
  input  logic     rdy_q,
  output port_st_e st
);
  localparam int MAXC = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] S_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] R_LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_HIZ;
      cnt <= '0;
    end else if (!share) begin
      st  <= ST_HIZ;
      cnt <= '0;
    end else if (!media_ok || !rdy_q) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_HIZ: begin
          st  <= ST_RST;
          cnt <= '0;
        end
        ST_IDLE: begin
          st  <= ST_WAIT;
          cnt <= '0;
        end
        ST_WAIT: begin
          if (cnt == S_LAST) begin
            st  <= ST_RST;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RST: begin
          if (cnt == R_LAST) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN:  st <= ST_RUN;
        default: st <= ST_HIZ;
      endcase
    end
  end

  // R6: share disable releases the port on the next edge
  a_r6_share_off_releases: assert property (@(posedge clk) disable iff (rst)
    !share |=> st == ST_HIZ);
  // R8: absent media holds the port in forced-zero mode
  a_r8_media_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (share && !media_ok) |=> st == ST_IDLE);
  // R3, R7: the reset pulse is entered only after settle or from release
  a_r3_reset_entry: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RST && $past(st) != ST_RST) |-> ($past(st) == ST_WAIT || $past(st) == ST_HIZ));
  // R5: active mode is entered only from the reset pulse
  a_r5_run_after_reset: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st) != ST_RUN) |-> $past(st) == ST_RST);
endmodule

// File: rtl/drive_port_ctrl.sv
module drive_port_ctrl
  import dpc_pkg::*;
#(
  parameter int QUAL_CYC   = 750000,
  parameter int SETTLE_CYC = 750000,
  parameter int EJECT_CYC  = 300000,
  parameter int RST_CYC    = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_rdy_pol,
  input  logic cfg_media_en,
  input  logic cfg_media_pol,
  input  logic rdy_in,
  input  logic media_in,
  input  logic share_en,
  input  logic eject_n,
  input  logic usb_suspend,
  input  logic wake_en,
  output logic drv_oe,
  output logic drv_active,
  output logic drv_rst,
  output logic bus_pu_oe,
  output logic bus_pu_val,
  output logic dplus_pu,
  output logic low_pwr,
  output logic eject_evt,
  output logic wake_req
);
  localparam int NIN = 4;
  // bit order: 3 eject_n, 2 share_en, 1 media_in, 0 rdy_in
  localparam logic [NIN-1:0] SYNC_RST = 4'b1000;

  logic [NIN-1:0] raw_v, syn_v;
  logic rdy_s, media_s, share_s, eject_s;
  logic rdy_a, rdy_q, media_ok_r, ej_q, ej_q_d, eject_d;
  port_st_e st;

  assign raw_v = {eject_n, share_en, media_in, rdy_in};

  dpc_sync #(.W(NIN), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  assign {eject_s, share_s, media_s, rdy_s} = syn_v;
  assign rdy_a = (rdy_s == cfg_rdy_pol);

  dpc_qual_filter #(.CYC(QUAL_CYC)) u_rdy_filt (
    .clk(clk), .rst(rst), .a(rdy_a), .q(rdy_q)
  );

  dpc_qual_filter #(.CYC(EJECT_CYC)) u_ej_filt (
    .clk(clk), .rst(rst), .a(!eject_s), .q(ej_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      media_ok_r <= 1'b0;
      ej_q_d     <= 1'b0;
      eject_evt  <= 1'b0;
      eject_d    <= 1'b1;
      wake_req   <= 1'b0;
    end else begin
      media_ok_r <= !cfg_media_en || (media_s == cfg_media_pol);
      ej_q_d     <= ej_q;
      eject_evt  <= ej_q && !ej_q_d;
      eject_d    <= eject_s;
      wake_req   <= usb_suspend && wake_en && (eject_s != eject_d);
    end
  end

  dpc_port_seq #(.SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst(rst), .share(share_s), .media_ok(media_ok_r),
    .rdy_q(rdy_q), .st(st)
  );

  assign drv_oe     = (st != ST_HIZ);
  assign drv_active = (st == ST_RUN);
  assign drv_rst    = (st == ST_RST);
  assign bus_pu_oe  = drv_oe;
  assign bus_pu_val = drv_active;
  assign dplus_pu   = media_ok_r;
  assign low_pwr    = !media_ok_r;

  // R9: an eject event lasts a single cycle
  a_r9_single_event: assert property (@(posedge clk) disable iff (rst)
    eject_evt |=> !eject_evt);
  // R10: a wakeup request needs suspend and permission in the cycle before
  a_r10_wake_needs_enable: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(usb_suspend && wake_en));
  // R8: media absence when enabled removes the D+ pull-up
  a_r8_pullup_drop: assert property (@(posedge clk) disable iff (rst)
    (cfg_media_en && $past(cfg_media_en) && (media_s != cfg_media_pol)
     && $stable(cfg_media_pol)) |=> !dplus_pu);
endmodule

// File: tb/tb_drive_port_ctrl.sv
module tb_drive_port_ctrl;
  localparam int Q = 20;
  localparam int S = 16;
  localparam int E = 12;
  localparam int R = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rdy_pol = 1'b1, cfg_media_en = 1'b1, cfg_media_pol = 1'b1;
  logic rdy_in = 1'b0, media_in = 1'b1, share_en = 1'b1, eject_n = 1'b1;
  logic usb_suspend = 1'b0, wake_en = 1'b0;
  logic drv_oe, drv_active, drv_rst, bus_pu_oe, bus_pu_val;
  logic dplus_pu, low_pwr, eject_evt, wake_req;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ej_cnt = 0, wk_cnt = 0, width = 0;
  logic prev_rst = 1'b0;
  bit done = 1'b0;
  int    sb_rise[$];
  int    sb_width[$];
  string sb_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  drive_port_ctrl #(.QUAL_CYC(Q), .SETTLE_CYC(S), .EJECT_CYC(E), .RST_CYC(R)) dut (
    .clk(clk), .rst(rst), .cfg_rdy_pol(cfg_rdy_pol), .cfg_media_en(cfg_media_en),
    .cfg_media_pol(cfg_media_pol), .rdy_in(rdy_in), .media_in(media_in),
    .share_en(share_en), .eject_n(eject_n), .usb_suspend(usb_suspend),
    .wake_en(wake_en), .drv_oe(drv_oe), .drv_active(drv_active), .drv_rst(drv_rst),
    .bus_pu_oe(bus_pu_oe), .bus_pu_val(bus_pu_val), .dplus_pu(dplus_pu),
    .low_pwr(low_pwr), .eject_evt(eject_evt), .wake_req(wake_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic expect_reset(input int rise, input string tag);
    sb_rise.push_back(rise);
    sb_width.push_back(R);
    sb_tag.push_back(tag);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected reset pulses and compares rise cycle and width
  always @(negedge clk) begin
    if (!rst) begin
      if (eject_evt) ej_cnt++;
      if (wake_req) wk_cnt++;
      if (drv_rst && !prev_rst) begin
        width = 1;
        if (sb_rise.size() == 0) check("R3 unexpected drive reset", cyc, -1);
        else check({sb_tag[0], " reset rise cycle"}, cyc, sb_rise[0]);
      end else if (drv_rst) begin
        width++;
      end
      if (!drv_rst && prev_rst && sb_rise.size() != 0) begin
        check({sb_tag[0], " reset width"}, width, sb_width[0]);
        void'(sb_rise.pop_front());
        void'(sb_width.pop_front());
        void'(sb_tag.pop_front());
      end
      prev_rst = drv_rst;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int t0;
    wait_n(4);
    check("R11 drv_oe", drv_oe, 0);
    check("R11 drv_active", drv_active, 0);
    check("R11 drv_rst", drv_rst, 0);
    check("R11 bus_pu_oe", bus_pu_oe, 0);
    check("R11 dplus_pu", dplus_pu, 0);
    check("R11 low_pwr", low_pwr, 1);
    rst = 1'b0;
    wait_n(6);
    check("R4 drv_oe", drv_oe, 1);
    check("R4 drv_active", drv_active, 0);
    check("R4 bus_pu_oe", bus_pu_oe, 1);
    check("R4 bus_pu_val", bus_pu_val, 0);
    check("R8 dplus_pu present", dplus_pu, 1);

    // R2: pulse a few cycles short of qualification
    rdy_in = 1'b1;
    wait_n(Q - 4);
    rdy_in = 1'b0;
    wait_n(40);
    check("R2 short ready pulse", drv_active, 0);

    // R3: full qualification, settle, reset pulse
    t0 = cyc;
    expect_reset(t0 + Q + S + 3, "R3");
    rdy_in = 1'b1;
    wait_n(Q + S + R + 10);
    check("R5 drv_active", drv_active, 1);
    check("R5 bus_pu_val", bus_pu_val, 1);

    // R2: immediate clear
    rdy_in = 1'b0;
    wait_n(4);
    check("R2 clear on deassert", drv_active, 0);

    // R1: active-low polarity, rdy_in already low
    t0 = cyc;
    expect_reset(t0 + Q + S + 1, "R1");
    cfg_rdy_pol = 1'b0;
    wait_n(Q + S + R + 10);
    check("R1 low polarity run", drv_active, 1);
    rdy_in = 1'b1;
    wait_n(6);
    check("R1 low polarity deassert", drv_active, 0);
    t0 = cyc;
    expect_reset(t0 + Q + S + 1, "R1");
    cfg_rdy_pol = 1'b1;
    wait_n(Q + S + R + 10);
    check("R1 high polarity run", drv_active, 1);

    // R6: release the bus
    share_en = 1'b0;
    wait_n(4);
    check("R6 drv_oe", drv_oe, 0);
    check("R6 bus_pu_oe", bus_pu_oe, 0);
    check("R6 dplus_pu unchanged", dplus_pu, 1);

    // R7: share back, reset without settle
    t0 = cyc;
    expect_reset(t0 + 3, "R7");
    share_en = 1'b1;
    wait_n(R + 8);
    check("R7 run after reshare", drv_active, 1);

    // R8: media removed and returned
    media_in = 1'b0;
    wait_n(6);
    check("R8 dplus_pu off", dplus_pu, 0);
    check("R8 low_pwr", low_pwr, 1);
    check("R8 forced zero oe", drv_oe, 1);
    check("R8 forced zero active", drv_active, 0);
    t0 = cyc;
    expect_reset(t0 + S + 4, "R8");
    media_in = 1'b1;
    wait_n(S + R + 10);
    check("R8 run after media return", drv_active, 1);
    check("R8 low_pwr cleared", low_pwr, 0);

    // R8: media function disabled, then active-low media polarity
    cfg_media_en = 1'b0;
    media_in = 1'b0;
    wait_n(8);
    check("R8 disabled media ignored dplus", dplus_pu, 1);
    check("R8 disabled media ignored run", drv_active, 1);
    cfg_media_pol = 1'b0;
    wait_n(2);
    cfg_media_en = 1'b1;
    wait_n(8);
    check("R8 low polarity present", drv_active, 1);
    check("R8 low polarity dplus", dplus_pu, 1);

    // R9: long and short eject presses
    eject_n = 1'b0;
    wait_n(E + 6);
    eject_n = 1'b1;
    wait_n(10);
    check("R9 long press event", ej_cnt, 1);
    eject_n = 1'b0;
    wait_n(E - 4);
    eject_n = 1'b1;
    wait_n(10);
    check("R9 short press no event", ej_cnt, 1);

    // R10: wakeup on eject edges while suspended
    usb_suspend = 1'b1;
    eject_n = 1'b0;
    wait_n(3);
    eject_n = 1'b1;
    wait_n(8);
    check("R10 no wake without enable", wk_cnt, 0);
    wake_en = 1'b1;
    eject_n = 1'b0;
    wait_n(3);
    eject_n = 1'b1;
    wait_n(8);
    check("R10 wake per edge", wk_cnt, 2);
    check("R9 no event from short presses", ej_cnt, 1);

    check("R3 no pending resets", sb_rise.size(), 0);
    finish_up();
  end
endmodule